// File: doc/BRIEF.md
# Coherence Single-Writer Invariant Monitor

This block watches the coherence states that a group of caches report for one line address and decides, on every sampled cycle, whether the combination is allowed. A combination is allowed if there is one writer and no other holder, or if there is no writer and any number of read-only holders. The monitor is synthesizable. It is meant to sit beside a coherence fabric, either in silicon or in an emulation build. Its job is to catch a broken invariant the moment it appears, even when the bad combination lasts for a single cycle.

Each sample carries a packed vector of per-cache states, a valid strobe and the address tag of the line. The monitor counts the caches that hold the line modified, exclusive and shared. It registers those counts and judges the combination. On the first illegal combination it raises a sticky error flag. It also records the lowest-numbered cache that took part in the conflict and the tag of the line. That record is kept until software or a test harness issues a synchronous clear. Only one address is monitored at a time, and the monitor never acts on the caches.

Top module: `coh_swmr_monitor`

## Requirements
- R1: Cache i reports its state on bits [2i+1:2i] of `smp_state_i`, encoded Invalid=2'b00, Shared=2'b01, Exclusive=2'b10, Modified=2'b11.
- R2: After a clock edge that samples with `smp_valid_i` high, `cnt_mod_o`, `cnt_exc_o` and `cnt_shr_o` hold the number of caches in Modified, Exclusive and Shared in that sample.
- R3: A sample with exactly one Modified holder and every other cache Invalid is legal and does not raise the error.
- R4: A sample with no Modified holder is legal when it has either at most one Exclusive holder and no Shared holder, or no Exclusive holder and any number of Shared holders.
- R5: Each of the following raises the error: two or more Modified holders, Modified together with Shared, Modified together with Exclusive, two or more Exclusive holders, or Exclusive together with Shared.
- R6: An illegal sample sets `err_o` at the clock edge that samples it. `err_o` then stays high through later legal or idle cycles until it is cleared.
- R7: On the edge that sets the error, `err_idx_o` captures the lowest index whose state is not Invalid, and `err_tag_o` captures `smp_tag_i`. Later illegal samples do not change these values while the error is held.
- R8: `err_clr_i` clears `err_o` at the next edge. If an illegal sample is taken at that same edge, the new violation wins: `err_o` stays high and the index and tag of the new sample are captured.
- R9: A cycle with `smp_valid_i` low is ignored. It cannot raise the error, and the counts keep their previous values.
- R10: After reset, `err_o`, `err_idx_o`, `err_tag_o` and all three counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| smp_valid_i | input | 1 | The state vector and tag are valid this cycle |
| smp_tag_i | input | TAG_W | Address tag of the monitored line |
| smp_state_i | input | 2*NUM_CACHES | Packed per-cache coherence states |
| err_clr_i | input | 1 | Synchronous clear of the sticky error |
| err_o | output | 1 | Sticky invariant-violation flag |
| err_idx_o | output | IDX_W | Lowest cache index involved in the first violation |
| err_tag_o | output | TAG_W | Tag of the line in the first violation |
| cnt_mod_o | output | CNT_W | Modified holders in the last valid sample |
| cnt_exc_o | output | CNT_W | Exclusive holders in the last valid sample |
| cnt_shr_o | output | CNT_W | Shared holders in the last valid sample |

## Verification
The sticky-error clear and the capture of a new violation can land on the same clock edge. When they do, the new violation must win. The bench provokes this in two ways. First, it holds the clear high while it presents an illegal sample that comes right after an earlier captured error. Second, it sweeps every one of the 256 four-cache state combinations with the clear held high throughout, so each sample is judged on its own. The bench passes the case only if the flag stays set and the index and tag belong to the newer sample. It also checks that a legal sample arriving with the clear leaves the flag low.

// File: rtl/coh_swmr_pkg.sv
package coh_swmr_pkg;

    typedef enum logic [1:0] {
        CST_INV = 2'b00,
        CST_SHR = 2'b01,
        CST_EXC = 2'b10,
        CST_MOD = 2'b11
    } coh_state_e;

endpackage

// File: rtl/coh_state_counter.sv
module coh_state_counter
    import coh_swmr_pkg::*;
#(
    parameter int NUM_CACHES = 4,
    parameter int CNT_W      = $clog2(NUM_CACHES + 1)
) (
    input  logic [2*NUM_CACHES-1:0] state_i,
    output logic [NUM_CACHES-1:0]   holder_o,
    output logic [CNT_W-1:0]        cnt_mod_o,
    output logic [CNT_W-1:0]        cnt_exc_o,
    output logic [CNT_W-1:0]        cnt_shr_o
);

    logic [NUM_CACHES-1:0] is_mod;
    logic [NUM_CACHES-1:0] is_exc;
    logic [NUM_CACHES-1:0] is_shr;

    // Decode each cache slice into one-hot class flags.
    for (genvar gi = 0; gi < NUM_CACHES; gi++) begin : g_dec
        coh_state_e st;
        assign st           = coh_state_e'(state_i[2*gi +: 2]);
        assign is_mod[gi]   = (st == CST_MOD);
        assign is_exc[gi]   = (st == CST_EXC);
        assign is_shr[gi]   = (st == CST_SHR);
        assign holder_o[gi] = (st != CST_INV);
    end

    always_comb begin
        cnt_mod_o = '0;
        cnt_exc_o = '0;
        cnt_shr_o = '0;
        for (int i = 0; i < NUM_CACHES; i++) begin
            cnt_mod_o = cnt_mod_o + CNT_W'(is_mod[i]);
            cnt_exc_o = cnt_exc_o + CNT_W'(is_exc[i]);
            cnt_shr_o = cnt_shr_o + CNT_W'(is_shr[i]);
        end
    end

endmodule

// File: rtl/coh_swmr_judge.sv
module coh_swmr_judge #(
    parameter int NUM_CACHES = 4,
    parameter int CNT_W      = $clog2(NUM_CACHES + 1),
    parameter int IDX_W      = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1
) (
    input  logic [NUM_CACHES-1:0] holder_i,
    input  logic [CNT_W-1:0]      cnt_mod_i,
    input  logic [CNT_W-1:0]      cnt_exc_i,
    input  logic [CNT_W-1:0]      cnt_shr_i,
    output logic                  viol_o,
    output logic [IDX_W-1:0]      first_idx_o
);

    logic one_writer_ok;
    logic readers_ok;

    always_comb begin
        // One writer, nobody else holds the line.
        one_writer_ok = (cnt_mod_i == CNT_W'(1)) && (cnt_exc_i == '0)
                        && (cnt_shr_i == '0);
        // No writer: a lone exclusive holder, or only shared holders.
        readers_ok    = (cnt_mod_i == '0)
                        && ((cnt_exc_i == '0)
                            || ((cnt_exc_i == CNT_W'(1)) && (cnt_shr_i == '0)));
        viol_o        = !(one_writer_ok || readers_ok);
    end

    // Lowest-numbered cache that holds the line in any valid state.
    always_comb begin
        first_idx_o = '0;
        for (int i = NUM_CACHES - 1; i >= 0; i--) begin
            if (holder_i[i]) begin
                first_idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/coh_swmr_monitor.sv
module coh_swmr_monitor #(
    parameter int NUM_CACHES = 4,
    parameter int TAG_W      = 16,
    parameter int CNT_W      = $clog2(NUM_CACHES + 1),
    parameter int IDX_W      = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    smp_valid_i,
    input  logic [TAG_W-1:0]        smp_tag_i,
    input  logic [2*NUM_CACHES-1:0] smp_state_i,
    input  logic                    err_clr_i,
    output logic                    err_o,
    output logic [IDX_W-1:0]        err_idx_o,
    output logic [TAG_W-1:0]        err_tag_o,
    output logic [CNT_W-1:0]        cnt_mod_o,
    output logic [CNT_W-1:0]        cnt_exc_o,
    output logic [CNT_W-1:0]        cnt_shr_o
);

    typedef struct packed {
        logic             err;
        logic [IDX_W-1:0] idx;
        logic [TAG_W-1:0] tag;
        logic [CNT_W-1:0] cm;
        logic [CNT_W-1:0] ce;
        logic [CNT_W-1:0] cs;
    } mon_regs_t;

    mon_regs_t regs_d, regs_q;

    logic [NUM_CACHES-1:0] holder_c;
    logic [CNT_W-1:0]      cm_c, ce_c, cs_c;
    logic                  viol_c;
    logic [IDX_W-1:0]      first_idx_c;

    coh_state_counter #(
        .NUM_CACHES (NUM_CACHES),
        .CNT_W      (CNT_W)
    ) i_counter (
        .state_i   (smp_state_i),
        .holder_o  (holder_c),
        .cnt_mod_o (cm_c),
        .cnt_exc_o (ce_c),
        .cnt_shr_o (cs_c)
    );

    coh_swmr_judge #(
        .NUM_CACHES (NUM_CACHES),
        .CNT_W      (CNT_W),
        .IDX_W      (IDX_W)
    ) i_judge (
        .holder_i    (holder_c),
        .cnt_mod_i   (cm_c),
        .cnt_exc_i   (ce_c),
        .cnt_shr_i   (cs_c),
        .viol_o      (viol_c),
        .first_idx_o (first_idx_c)
    );

    always_comb begin
        regs_d = regs_q;
        if (err_clr_i) begin
            regs_d.err = 1'b0;
        end
        if (smp_valid_i) begin
            regs_d.cm = cm_c;
            regs_d.ce = ce_c;
            regs_d.cs = cs_c;
            // A held error keeps its first record; a clear frees the slot.
            if (viol_c && (!regs_q.err || err_clr_i)) begin
                regs_d.err = 1'b1;
                regs_d.idx = first_idx_c;
                regs_d.tag = smp_tag_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign err_o     = regs_q.err;
    assign err_idx_o = regs_q.idx;
    assign err_tag_o = regs_q.tag;
    assign cnt_mod_o = regs_q.cm;
    assign cnt_exc_o = regs_q.ce;
    assign cnt_shr_o = regs_q.cs;

    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(cnt_mod_o) + int'(cnt_exc_o) + int'(cnt_shr_o)) <= NUM_CACHES); // R2

    AST_MULTI_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_valid_i && (cm_c > CNT_W'(1)) |=> err_o); // R5

    AST_SET_ON_VIOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_valid_i && viol_c |=> err_o); // R6

    AST_RECORD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o && !err_clr_i |=> err_o && $stable(err_idx_o) && $stable(err_tag_o)); // R7

    AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_clr_i && !(smp_valid_i && viol_c) |=> !err_o); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !smp_valid_i |=> $stable(cnt_mod_o) && $stable(cnt_exc_o) && $stable(cnt_shr_o)); // R9

endmodule

// File: tb/test_coh_swmr_monitor.sv
module test_coh_swmr_monitor;

    localparam int N     = 4;
    localparam int TAG_W = 16;
    localparam int CNT_W = $clog2(N + 1);
    localparam int IDX_W = $clog2(N);

    // R1 encoding
    localparam logic [1:0] I_ = 2'b00, S_ = 2'b01, E_ = 2'b10, M_ = 2'b11;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 vld = 1'b0;
    logic [TAG_W-1:0]     tag = '0;
    logic [2*N-1:0]       st = '0;
    logic                 clr = 1'b0;
    logic                 err;
    logic [IDX_W-1:0]     eidx;
    logic [TAG_W-1:0]     etag;
    logic [CNT_W-1:0]     cm, ce, cs;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    coh_swmr_monitor #(.NUM_CACHES(N), .TAG_W(TAG_W)) i_coh_swmr_monitor (
        .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(vld), .smp_tag_i(tag),
        .smp_state_i(st), .err_clr_i(clr), .err_o(err), .err_idx_o(eidx),
        .err_tag_o(etag), .cnt_mod_o(cm), .cnt_exc_o(ce), .cnt_shr_o(cs)
    );

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic logic [2*N-1:0] pk(input logic [1:0] c3, input logic [1:0] c2,
                                          input logic [1:0] c1, input logic [1:0] c0);
        return {c3, c2, c1, c0};
    endfunction

    // Drive at a falling edge, let one rising edge sample, return at the next falling edge.
    task automatic apply(input logic [2*N-1:0] s, input logic [TAG_W-1:0] t,
                         input logic v, input logic c);
        st = s; tag = t; vld = v; clr = c;
        @(negedge clk);
        vld = 1'b0; clr = 1'b0;
    endtask

    task automatic expect_counts(input string tg, input logic [2*N-1:0] s);
        int m = 0, e = 0, h = 0;
        for (int i = 0; i < N; i++) begin
            if (s[2*i +: 2] == M_) m++;
            if (s[2*i +: 2] == E_) e++;
            if (s[2*i +: 2] == S_) h++;
        end
        check({tg, " cnt_mod"}, int'(cm), m);
        check({tg, " cnt_exc"}, int'(ce), e);
        check({tg, " cnt_shr"}, int'(cs), h);
    endtask

    task automatic t_reset;
        check("R10 err", int'(err), 0);
        check("R10 idx", int'(eidx), 0);
        check("R10 tag", int'(etag), 0);
        check("R10 counts", int'(cm) + int'(ce) + int'(cs), 0);
    endtask

    task automatic t_legal;
        logic [2*N-1:0] pats [5];
        pats[0] = pk(I_, I_, I_, I_);
        pats[1] = pk(I_, M_, I_, I_);
        pats[2] = pk(E_, I_, I_, I_);
        pats[3] = pk(S_, I_, S_, S_);
        pats[4] = pk(S_, S_, S_, S_);
        foreach (pats[k]) begin
            apply(pats[k], 16'h1000 + 16'(k), 1'b1, 1'b0);
            check("R3/R4 legal no err", int'(err), 0);
            expect_counts("R1/R2", pats[k]);
        end
    endtask

    task automatic t_illegal;
        logic [2*N-1:0] pats [5];
        int             idx  [5];
        pats[0] = pk(M_, I_, M_, I_); idx[0] = 1;
        pats[1] = pk(S_, M_, I_, I_); idx[1] = 2;
        pats[2] = pk(I_, E_, I_, M_); idx[2] = 0;
        pats[3] = pk(E_, E_, I_, I_); idx[3] = 2;
        pats[4] = pk(E_, I_, I_, S_); idx[4] = 0;
        foreach (pats[k]) begin
            apply(pats[k], 16'hB000 + 16'(k), 1'b1, 1'b0);
            check("R5/R6 err set", int'(err), 1);
            check("R7 idx", int'(eidx), idx[k]);
            check("R7 tag", int'(etag), 32'hB000 + k);
            expect_counts("R2 illegal", pats[k]);
            apply('0, '0, 1'b0, 1'b1);
            check("R8 cleared", int'(err), 0);
        end
    endtask

    task automatic t_sticky;
        apply(pk(I_, I_, M_, M_), 16'h0A0A, 1'b1, 1'b0);
        apply(pk(E_, E_, I_, I_), 16'h0B0B, 1'b1, 1'b0);
        check("R7 first idx kept", int'(eidx), 0);
        check("R7 first tag kept", int'(etag), 32'h0A0A);
        apply(pk(I_, I_, I_, S_), 16'h0C0C, 1'b1, 1'b0);
        check("R6 sticky after legal", int'(err), 1);
        repeat (3) @(negedge clk);
        check("R6 sticky idle", int'(err), 1);
        // clear collides with a new violation
        apply(pk(M_, S_, I_, I_), 16'h0D0D, 1'b1, 1'b1);
        check("R8 collide err", int'(err), 1);
        check("R8 collide idx", int'(eidx), 2);
        check("R8 collide tag", int'(etag), 32'h0D0D);
        apply(pk(I_, I_, E_, I_), 16'h0E0E, 1'b1, 1'b1);
        check("R8 clear with legal", int'(err), 0);
    endtask

    task automatic t_ignore;
        apply(pk(S_, S_, I_, E_), 16'h2222, 1'b1, 1'b0);
        check("R4 E alone? no (E+S)", int'(err), 1);
        apply('0, '0, 1'b0, 1'b1);
        apply(pk(I_, I_, S_, S_), 16'h3333, 1'b1, 1'b0);
        apply(pk(M_, M_, M_, M_), 16'h4444, 1'b0, 1'b0);
        check("R9 invalid no err", int'(err), 0);
        expect_counts("R9 counts held", pk(I_, I_, S_, S_));
    endtask

    task automatic t_sweep;
        for (int p = 0; p < 256; p++) begin
            logic [2*N-1:0] s;
            int m = 0, e = 0, h = 0, lo = -1;
            bit legal;
            s = 8'(p);
            for (int i = 0; i < N; i++) begin
                if (s[2*i +: 2] == M_) m++;
                if (s[2*i +: 2] == E_) e++;
                if (s[2*i +: 2] == S_) h++;
                if (s[2*i +: 2] != I_ && lo < 0) lo = i;
            end
            legal = (m == 1 && e == 0 && h == 0) || (m == 0 && (e == 0 || (e == 1 && h == 0)));
            apply(s, 16'(p) ^ 16'hA5A5, 1'b1, 1'b1);
            check("R3/R4/R5/R8 sweep err", int'(err), legal ? 0 : 1);
            if (!legal) begin
                check("R7 sweep idx", int'(eidx), lo);
                check("R7 sweep tag", int'(etag), int'(16'(p) ^ 16'hA5A5));
            end
            expect_counts("R2 sweep", s);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_legal();
        t_illegal();
        t_sticky();
        t_ignore();
        t_sweep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule